// File: doc/BRIEF.md
# Bit-Serial Register Access Port

This block lets a host reach a small bank of 8-bit modem registers over a handful of wires. Three address inputs pick the register. An active-low read strobe, an active-low write strobe and a shift clock sequence each transfer, and one data pin carries the bits in both directions, least significant bit first. The pad is split into an input, an output and an output enable, so the pin's tri-state buffer lives outside the block.

Three read/write registers sit in the bank: control A, control B and tone. Their contents are exported so that the rest of the modem can use them. A read-only detect register is loaded every cycle from the modem's status logic, and the host cannot change it. All pins are sampled on the system clock. Edges of the shift clock and the write strobe are detected against a registered copy of the pin.

Top module: `serial_reg_port`

## Requirements
- R1: While `rd_n` is low, `sdata_oe` is 1 and `sdata_o` carries bit 0 of the addressed register, with no shift-clock edge needed.
- R2: During a read, each detected rising edge of `sck` moves `sdata_o` to the next higher bit. After bit 7 has been reached, further edges keep bit 7 on the pin.
- R3: While `rd_n` is high, `sdata_oe` is 0.
- R4: Every detected rising edge of `sck` shifts `sdata_i` into an 8-bit shift register, whatever state the strobes are in. The earliest of the last eight bits becomes bit 0, so only the last eight bits are kept.
- R5: A read/write register loads the shift register only on the clock that follows the low-to-high transition of `wr_n`. It is unchanged while `wr_n` is held low.
- R6: Address 0 is control A, address 1 is control B and address 2 is tone, all read/write. Address 3 reads the detect register, which holds `det_i` as it was one clock earlier. A write to address 3 changes nothing.
- R7: Addresses 4 to 7 read as all zeros, and writes to them change no register.
- R8: A synchronous active-high `rst` clears control A, control B and tone to zero.
- R9: `ctrl_a_o`, `ctrl_b_o` and `tone_o` always show the current contents of their registers.
- R10: Each new low period of `rd_n` starts again at bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | 3 | Register select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe; commits on its rising edge |
| sck | input | 1 | Shift clock, sampled on clk |
| sdata_i | input | 1 | Data pin, input side |
| sdata_o | output | 1 | Data pin, output side |
| sdata_oe | output | 1 | Data pin output enable |
| det_i | input | 8 | Status bits from the modem detectors |
| ctrl_a_o | output | 8 | Control A contents |
| ctrl_b_o | output | 8 | Control B contents |
| tone_o | output | 8 | Tone register contents |

## Verification
The bench uses the default widths: 8-bit registers and a 3-bit address. With a 3-bit address every one of the eight codes can be tried, so the unused range 4 to 7 is exercised alongside the four real registers. With 8-bit data, the saturation at bit 7 and a shift-clock run longer than eight bits before a write are short enough to drive directly. Random writes, reads, detector updates and stray shift clocks are mixed with directed cases.

// File: rtl/srp_pkg.sv
package srp_pkg;
  localparam int unsigned SRP_DW = 8;
  localparam int unsigned SRP_AW = 3;
  localparam int unsigned SRP_NRW = 3;
  localparam int unsigned SRP_DET_ADDR = 3;
endpackage

// File: rtl/srp_edge.sv
module srp_edge #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  output logic rise_o
);
  logic pin_q;

  always_ff @(posedge clk) begin
    if (rst) pin_q <= RST_VAL;
    else     pin_q <= pin_i;
  end

  assign rise_o = pin_i & ~pin_q;
endmodule

// File: rtl/srp_wshift.sv
module srp_wshift #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          shift_i,
  input  logic          bit_i,
  output logic [DW-1:0] word_o
);
  logic [DW-1:0] sr_q;

  always_ff @(posedge clk) begin
    if (rst)          sr_q <= '0;
    else if (shift_i) sr_q <= {bit_i, sr_q[DW-1:1]};
  end

  assign word_o = sr_q;

  // R4: the newest bit enters at the top
  a_r4_shift_in: assert property (@(posedge clk) disable iff (rst)
    shift_i |=> sr_q[DW-1] == $past(bit_i));
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    !shift_i |=> $stable(sr_q));
endmodule

// File: rtl/srp_bank.sv
module srp_bank #(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 3,
  parameter int unsigned NRW = 3,
  parameter int unsigned DET_ADDR = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              commit_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [DW-1:0]     det_i,
  output logic [NRW*DW-1:0] rw_flat_o,
  output logic [DW-1:0]     rd_byte_o
);
  logic [DW-1:0] det_q;

  for (genvar g = 0; g < NRW; g++) begin : g_rw
    logic [DW-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)                                q <= '0;
      else if (commit_i && addr_i == AW'(g))  q <= wdata_i;
    end
    assign rw_flat_o[g*DW +: DW] = q;
  end

  always_ff @(posedge clk) begin
    if (rst) det_q <= '0;
    else     det_q <= det_i;
  end

  always_comb begin
    rd_byte_o = '0;
    for (int i = 0; i < NRW; i++) begin
      if (addr_i == AW'(i)) rd_byte_o = rw_flat_o[i*DW +: DW];
    end
    if (addr_i == AW'(DET_ADDR)) rd_byte_o = det_q;
  end

  // R5: registers move only on a commit
  a_r5_no_commit_stable: assert property (@(posedge clk) disable iff (rst)
    !commit_i |=> $stable(rw_flat_o));
  // R6: detect register tracks status input, never the host
  a_r6_detect_follows: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> det_q == $past(det_i));
  // R7: unused addresses never alter storage
  a_r7_unused_write: assert property (@(posedge clk) disable iff (rst)
    (addr_i >= AW'(NRW)) |=> $stable(rw_flat_o));
endmodule

// File: rtl/srp_rdser.sv
module srp_rdser #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_n,
  input  logic          step_i,
  input  logic [DW-1:0] byte_i,
  output logic          bit_o,
  output logic          oe_o
);
  localparam int unsigned PW = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [PW-1:0] LAST = PW'(DW - 1);

  logic [PW-1:0] ptr_q;

  always_ff @(posedge clk) begin
    if (rst || rd_n)                 ptr_q <= '0;
    else if (step_i && ptr_q != LAST) ptr_q <= ptr_q + 1'b1;
  end

  assign bit_o = byte_i[ptr_q];
  assign oe_o  = ~rd_n;

  // R2: one step per detected shift edge, saturating at the top bit
  a_r2_step: assert property (@(posedge clk) disable iff (rst)
    (!rd_n && step_i && ptr_q != LAST) |=> ptr_q == $past(ptr_q) + 1'b1);
  a_r2_saturate: assert property (@(posedge clk) disable iff (rst)
    (!rd_n && ptr_q == LAST) |=> (rd_n || ptr_q == LAST) || ptr_q == '0);
  // R10: an idle read strobe parks the pointer at bit 0
  a_r10_restart: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_n) |=> ptr_q == '0);
endmodule

// File: rtl/serial_reg_port.sv
module serial_reg_port
  import srp_pkg::*;
#(
  parameter int unsigned DW = SRP_DW,
  parameter int unsigned AW = SRP_AW,
  parameter int unsigned DET_ADDR = SRP_DET_ADDR
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr_i,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic          sck,
  input  logic          sdata_i,
  output logic          sdata_o,
  output logic          sdata_oe,
  input  logic [DW-1:0] det_i,
  output logic [DW-1:0] ctrl_a_o,
  output logic [DW-1:0] ctrl_b_o,
  output logic [DW-1:0] tone_o
);
  localparam int unsigned NRW = SRP_NRW;

  logic sck_rise;
  logic wr_rise;
  logic [DW-1:0] shift_word;
  logic [DW-1:0] rd_byte;
  logic [NRW*DW-1:0] rw_flat;

  srp_edge #(.RST_VAL(1'b0)) u_sck_edge (
    .clk(clk), .rst(rst), .pin_i(sck), .rise_o(sck_rise)
  );

  srp_edge #(.RST_VAL(1'b1)) u_wr_edge (
    .clk(clk), .rst(rst), .pin_i(wr_n), .rise_o(wr_rise)
  );

  srp_wshift #(.DW(DW)) u_wshift (
    .clk(clk), .rst(rst), .shift_i(sck_rise), .bit_i(sdata_i),
    .word_o(shift_word)
  );

  srp_bank #(.DW(DW), .AW(AW), .NRW(NRW), .DET_ADDR(DET_ADDR)) u_bank (
    .clk(clk), .rst(rst), .commit_i(wr_rise), .addr_i(addr_i),
    .wdata_i(shift_word), .det_i(det_i), .rw_flat_o(rw_flat),
    .rd_byte_o(rd_byte)
  );

  srp_rdser #(.DW(DW)) u_rdser (
    .clk(clk), .rst(rst), .rd_n(rd_n), .step_i(sck_rise),
    .byte_i(rd_byte), .bit_o(sdata_o), .oe_o(sdata_oe)
  );

  assign ctrl_a_o = rw_flat[0*DW +: DW];
  assign ctrl_b_o = rw_flat[1*DW +: DW];
  assign tone_o   = rw_flat[2*DW +: DW];

  // R3: pin released outside a read
  a_r3_release: assert property (@(posedge clk) disable iff (rst)
    rd_n |-> !sdata_oe);
  // R7: unused addresses shift out zeros
  a_r7_zero_read: assert property (@(posedge clk) disable iff (rst)
    (!rd_n && addr_i >= AW'(NRW) && addr_i != AW'(DET_ADDR)) |-> !sdata_o);
  // R8: reset empties the read/write registers
  a_r8_reset_clear: assert property (@(posedge clk)
    rst |=> (ctrl_a_o == '0 && ctrl_b_o == '0 && tone_o == '0));
  // R5: commit loads the shifted byte into the addressed register
  a_r5_commit_load: assert property (@(posedge clk) disable iff (rst)
    (wr_rise && addr_i == AW'(0)) |=> ctrl_a_o == $past(shift_word));
endmodule

// File: tb/tb_serial_reg_port.sv
module tb_serial_reg_port;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] addr_i = '0;
  logic rd_n = 1'b1, wr_n = 1'b1, sck = 1'b0, sdata_i = 1'b0;
  logic sdata_o, sdata_oe;
  logic [7:0] det_i = '0;
  logic [7:0] ctrl_a_o, ctrl_b_o, tone_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] m_rw [3];
  logic [7:0] m_det;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_reg_port dut (
    .clk(clk), .rst(rst), .addr_i(addr_i), .rd_n(rd_n), .wr_n(wr_n),
    .sck(sck), .sdata_i(sdata_i), .sdata_o(sdata_o), .sdata_oe(sdata_oe),
    .det_i(det_i), .ctrl_a_o(ctrl_a_o), .ctrl_b_o(ctrl_b_o), .tone_o(tone_o)
  );

  function automatic logic [7:0] exp_byte(input logic [2:0] a);
    if (a < 3'd3) return m_rw[a];
    if (a == 3'd3) return m_det;
    return 8'h00;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic check_exports();
    check("R9 ctrl_a", 32'(ctrl_a_o), 32'(m_rw[0]));
    check("R9 ctrl_b", 32'(ctrl_b_o), 32'(m_rw[1]));
    check("R9 tone",   32'(tone_o),   32'(m_rw[2]));
  endtask

  task automatic sck_pulse(input logic b);
    @(negedge clk); sdata_i = b; sck = 1'b1;
    @(negedge clk); sck = 1'b0;
  endtask

  task automatic do_write(input logic [2:0] a, input logic [7:0] d, input int noise);
    for (int i = 0; i < noise; i++) sck_pulse(1'($urandom));
    for (int i = 0; i < 8; i++) sck_pulse(d[i]);
    @(negedge clk); addr_i = a; wr_n = 1'b0;
    @(negedge clk); #1;
    check("R5 held before strobe rise", 32'({ctrl_a_o, ctrl_b_o, tone_o}),
          32'({m_rw[0], m_rw[1], m_rw[2]}));
    wr_n = 1'b1;
    @(negedge clk); #1;
    if (a < 3'd3) m_rw[a] = d;
    check_exports();
  endtask

  task automatic do_read(input logic [2:0] a, input int extra);
    logic [7:0] e;
    @(negedge clk); addr_i = a; rd_n = 1'b0; #1;
    e = exp_byte(a);
    check("R1 oe", 32'(sdata_oe), 32'd1);
    check(a >= 3'd4 ? "R7 bit0" : "R1 bit0", 32'(sdata_o), 32'(e[0]));
    for (int k = 1; k < 8 + extra; k++) begin
      sck_pulse(1'($urandom)); #1;
      check(k > 7 ? "R2 saturate" : (a == 3'd3 ? "R6 bit" : "R2 bit"),
            32'(sdata_o), 32'(e[(k > 7) ? 7 : k]));
    end
    @(negedge clk); rd_n = 1'b1; #1;
    check("R3 released", 32'(sdata_oe), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 3; i++) m_rw[i] = '0;
    m_det = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #1;
    check("R8 reset ctrl_a", 32'(ctrl_a_o), 32'd0);
    check("R8 reset ctrl_b", 32'(ctrl_b_o), 32'd0);
    check("R8 reset tone",   32'(tone_o),   32'd0);
    check("R3 idle", 32'(sdata_oe), 32'd0);

    // directed cases
    do_write(3'd0, 8'hA5, 0);
    do_write(3'd1, 8'h3C, 5);           // R4 only last eight kept
    do_write(3'd2, 8'h81, 11);
    do_read(3'd0, 0);
    do_read(3'd1, 3);                   // R2 saturate past bit 7
    do_read(3'd0, 0);                   // R10 restart at bit 0
    @(negedge clk); det_i = 8'h6B;
    @(negedge clk); m_det = 8'h6B;
    do_read(3'd3, 0);                   // R6
    do_write(3'd3, 8'hFF, 0);           // R6 write ignored
    do_read(3'd3, 0);
    do_write(3'd5, 8'hEE, 2);           // R7 write ignored
    do_read(3'd6, 0);                   // R7 reads zero

    // random mix
    for (int n = 0; n < 250; n++) begin
      int op = int'($urandom_range(0, 3));
      if (op == 0) do_write(3'($urandom), 8'($urandom), int'($urandom_range(0, 4)));
      else if (op == 1) do_read(3'($urandom), int'($urandom_range(0, 2)));
      else if (op == 2) begin
        @(negedge clk); det_i = 8'($urandom);
        @(negedge clk); m_det = det_i;
      end else sck_pulse(1'($urandom));
    end

    // R8 reset mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    for (int i = 0; i < 3; i++) m_rw[i] = '0;
    m_det = '0;
    #1;
    check_exports();

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule